// File: doc/BRIEF.md
# Edge and Level Boundary-Scan Test Receiver

This block is the digital core of the test receiver in a boundary-scan input cell. An analog front end is assumed to supply four quantised indications: a qualified rising transition, a qualified falling transition, input above the upper hysteresis threshold, and input below the lower one. From these indications the block rebuilds the value that the upstream driver sent. It keeps that value in a hysteresis register and passes it to the capture register, which feeds the shift stage of the cell.

The block has two modes, chosen by the instruction class. With an AC test instruction in force, it follows transitions only. With the DC external-test instruction in force, it follows levels only. A separate "event seen" flag records whether any qualified event has arrived since history was last cleared. Each mode clears that flag at its own point in the TAP sequence. When the TAP leaves Capture-DR, the capture register takes the rebuilt value only if an event was seen. Otherwise it keeps what it held.

TCK and the TAP state arrive from the test controller. TCK passes through a synchroniser into the block's own clock, and all updates happen on that clock.

Top module: `edge_level_rx`

## Requirements
- R1: After reset, `hystBit` and `captBit` are 0 and no event is recorded.
- R2: With `acMode`=1, a `riseEvt` pulse (without `fallEvt`) sets `hystBit` to 1 and records an event, and a `fallEvt` pulse (without `riseEvt`) sets it to 0 and records an event. `aboveHi` and `belowLo` have no effect.
- R3: With `acMode`=0, `aboveHi` (without `belowLo`) sets `hystBit` to 1 and records an event, and `belowLo` (without `aboveHi`) sets it to 0 and records an event. `riseEvt` and `fallEvt` have no effect.
- R4: If both indications of the active mode are asserted together, `hystBit` keeps its value and no event is recorded.
- R5: `tapState` uses the codes Reset=0, Idle=1, SelDR=2, CapDR=3, ShiftDR=4, Exit1DR=5, PauseDR=6, Exit2DR=7, UpdDR=8, SelIR=9, CapIR=10, ShiftIR=11, Exit1IR=12, PauseIR=13, Exit2IR=14, UpdIR=15. With `acMode`=0, a falling TCK edge while `tapState`=3 (CapDR) clears the event record.
- R6: With `acMode`=1, a falling TCK edge while `tapState`=5 (Exit1DR) clears the event record. A falling edge in CapDR does not clear it.
- R7: On a rising TCK edge whose preceding falling edge occurred in CapDR, `captBit` loads `hystBit` if an event has been recorded since the last clear. Otherwise `captBit` keeps its value. `captBit` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every register updates on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| tck | input | 1 | Test clock from the test controller; asynchronous to `clk` |
| tapState | input | 4 | Current TAP controller state, coded as in R5 |
| acMode | input | 1 | 1: AC test instruction active (edge mode); 0: DC external test (level mode) |
| riseEvt | input | 1 | Qualified rising transition seen at the pin |
| fallEvt | input | 1 | Qualified falling transition seen at the pin |
| aboveHi | input | 1 | Pin level above bias plus hysteresis |
| belowLo | input | 1 | Pin level below bias minus hysteresis |
| hystBit | output | 1 | Rebuilt test value held in the hysteresis register |
| captBit | output | 1 | Capture register value presented to the shift stage |

## Verification
Directed sequences first take a single level, and then a single edge, through a full clear-to-capture window, which shows that each mode loads the rebuilt value. They then send an event only before the clear point and nothing after it, which separates a correct clear from a missing one, and send both indications at once, which separates holding from setting or clearing. In every case the inactive pair of indications carries random noise, so any leakage between the modes shows up in `hystBit`. A long random walk through the TAP state graph then mixes random events with changes of mode, and each TCK cycle is compared against a reference model of the event flag and the capture register.

// File: rtl/edge_level_rx_pkg.sv
package edge_level_rx_pkg;

  // TAP controller state codes as presented on the tapState port
  typedef enum logic [3:0] {
    TAP_RESET    = 4'd0,
    TAP_IDLE     = 4'd1,
    TAP_SEL_DR   = 4'd2,
    TAP_CAP_DR   = 4'd3,
    TAP_SHIFT_DR = 4'd4,
    TAP_EXIT1_DR = 4'd5,
    TAP_PAUSE_DR = 4'd6,
    TAP_EXIT2_DR = 4'd7,
    TAP_UPD_DR   = 4'd8,
    TAP_SEL_IR   = 4'd9,
    TAP_CAP_IR   = 4'd10,
    TAP_SHIFT_IR = 4'd11,
    TAP_EXIT1_IR = 4'd12,
    TAP_PAUSE_IR = 4'd13,
    TAP_EXIT2_IR = 4'd14,
    TAP_UPD_IR   = 4'd15
  } tapState_e;

  // Strobes from control to datapath, one clk wide each
  typedef struct packed {
    logic clearHist;
    logic loadCapt;
  } rxStrobe_t;

endpackage

// File: rtl/elr_tck_sync.sv
module elr_tck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tckIn,
  output logic tckOut
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign tckOut = tckIn;
    end else begin : g_chain
      logic [STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2+((STAGES==1)?1:0):0], tckIn} ;
      end
      assign tckOut = syncQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/elr_ctrl.sv
module elr_ctrl
  import edge_level_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tckSync,
  input  logic [3:0] tapState,
  input  logic       acMode,
  output rxStrobe_t  strobe
);

  logic      tckQ;
  logic      tckRise;
  logic      tckFall;
  tapState_e curState;
  tapState_e stateAtFall;
  logic      clearWin;

  assign curState = tapState_e'(tapState);
  assign tckRise  = tckSync & ~tckQ;
  assign tckFall  = ~tckSync & tckQ;

  // Clear point depends on the mode: edge mode clears on leaving shift,
  // level mode clears at the start of the capture window
  assign clearWin = acMode ? (curState == TAP_EXIT1_DR) : (curState == TAP_CAP_DR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tckQ        <= 1'b0;
      stateAtFall <= TAP_RESET;
      strobe      <= '0;
    end else begin
      tckQ             <= tckSync;
      if (tckFall) stateAtFall <= curState;
      strobe.clearHist <= tckFall & clearWin;
      strobe.loadCapt  <= tckRise & (stateAtFall == TAP_CAP_DR);
    end
  end

  // R7: a load strobe never coincides with a clear strobe
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearHist, strobe.loadCapt}));

endmodule

// File: rtl/elr_datapath.sv
module elr_datapath
  import edge_level_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      acMode,
  input  logic      riseEvt,
  input  logic      fallEvt,
  input  logic      aboveHi,
  input  logic      belowLo,
  input  rxStrobe_t strobe,
  output logic      hystBit,
  output logic      captBit
);

  logic hystQ;
  logic evtQ;
  logic captQ;
  logic upReq;
  logic downReq;

  // Only the pair belonging to the active mode is looked at
  always_comb begin
    if (acMode) begin
      upReq   = riseEvt & ~fallEvt;
      downReq = fallEvt & ~riseEvt;
    end else begin
      upReq   = aboveHi & ~belowLo;
      downReq = belowLo & ~aboveHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hystQ <= 1'b0;
      evtQ  <= 1'b0;
    end else if (strobe.clearHist) begin
      evtQ  <= 1'b0;
    end else if (upReq) begin
      hystQ <= 1'b1;
      evtQ  <= 1'b1;
    end else if (downReq) begin
      hystQ <= 1'b0;
      evtQ  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          captQ <= 1'b0;
    else if (strobe.loadCapt && evtQ)   captQ <= hystQ;
  end

  assign hystBit = hystQ;
  assign captBit = captQ;

  a_r2_edge_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    acMode && riseEvt && !fallEvt && !strobe.clearHist |=> hystQ);

  a_r3_level_low_clears: assert property (@(posedge clk) disable iff (!rstN)
    !acMode && belowLo && !aboveHi && !strobe.clearHist |=> !hystQ);

  a_r4_conflict_holds: assert property (@(posedge clk) disable iff (!rstN)
    (acMode ? (riseEvt && fallEvt) : (aboveHi && belowLo)) |=> $stable(hystQ));

  a_r5_clear_drops_event: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearHist |=> !evtQ);

  a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCapt |=> $stable(captQ));

endmodule

// File: rtl/edge_level_rx.sv
module edge_level_rx
  import edge_level_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tck,
  input  logic [3:0] tapState,
  input  logic       acMode,
  input  logic       riseEvt,
  input  logic       fallEvt,
  input  logic       aboveHi,
  input  logic       belowLo,
  output logic       hystBit,
  output logic       captBit
);

  logic      tckSync;
  rxStrobe_t strobe;

  elr_tck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .tckIn  (tck),
    .tckOut (tckSync)
  );

  elr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tckSync  (tckSync),
    .tapState (tapState),
    .acMode   (acMode),
    .strobe   (strobe)
  );

  elr_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .acMode  (acMode),
    .riseEvt (riseEvt),
    .fallEvt (fallEvt),
    .aboveHi (aboveHi),
    .belowLo (belowLo),
    .strobe  (strobe),
    .hystBit (hystBit),
    .captBit (captBit)
  );

endmodule

// File: tb/sim_edge_level_rx.sv
module sim_edge_level_rx;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] S_RESET = 4'd0, S_IDLE = 4'd1, S_SELDR = 4'd2, S_CAPDR = 4'd3,
    S_SHIFTDR = 4'd4, S_EXIT1DR = 4'd5, S_PAUSEDR = 4'd6, S_EXIT2DR = 4'd7, S_UPDDR = 4'd8,
    S_SELIR = 4'd9, S_CAPIR = 4'd10, S_SHIFTIR = 4'd11, S_EXIT1IR = 4'd12, S_PAUSEIR = 4'd13,
    S_EXIT2IR = 4'd14, S_UPDIR = 4'd15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tck = 1'b0;
  logic [3:0] tapState = S_RESET;
  logic acMode = 1'b0;
  logic riseEvt = 1'b0, fallEvt = 1'b0, aboveHi = 1'b0, belowLo = 1'b0;
  logic hystBit, captBit;

  int vecs = 0;
  int errs = 0;
  logic mHyst = 1'b0, mEvt = 1'b0, mCapt = 1'b0;
  logic [3:0] lastFall = S_RESET;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_level_rx u0 (
    .clk(clk), .rstN(rstN), .tck(tck), .tapState(tapState), .acMode(acMode),
    .riseEvt(riseEvt), .fallEvt(fallEvt), .aboveHi(aboveHi), .belowLo(belowLo),
    .hystBit(hystBit), .captBit(captBit)
  );

  function automatic logic [3:0] nextTap(input logic [3:0] s, input logic tms);
    case (s)
      S_RESET:   return tms ? S_RESET   : S_IDLE;
      S_IDLE:    return tms ? S_SELDR   : S_IDLE;
      S_SELDR:   return tms ? S_SELIR   : S_CAPDR;
      S_CAPDR:   return tms ? S_EXIT1DR : S_SHIFTDR;
      S_SHIFTDR: return tms ? S_EXIT1DR : S_SHIFTDR;
      S_EXIT1DR: return tms ? S_UPDDR   : S_PAUSEDR;
      S_PAUSEDR: return tms ? S_EXIT2DR : S_PAUSEDR;
      S_EXIT2DR: return tms ? S_UPDDR   : S_SHIFTDR;
      S_UPDDR:   return tms ? S_SELDR   : S_IDLE;
      S_SELIR:   return tms ? S_RESET   : S_CAPIR;
      S_CAPIR:   return tms ? S_EXIT1IR : S_SHIFTIR;
      S_SHIFTIR: return tms ? S_EXIT1IR : S_SHIFTIR;
      S_EXIT1IR: return tms ? S_UPDIR   : S_PAUSEIR;
      S_PAUSEIR: return tms ? S_EXIT2IR : S_PAUSEIR;
      S_EXIT2IR: return tms ? S_UPDIR   : S_SHIFTIR;
      default:   return tms ? S_SELDR   : S_IDLE;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One TCK half period of 8 clk; code 0 none, 1 up, 2 down, 3 both.
  // The pair of the inactive mode carries random noise.
  task automatic phase(input logic [1:0] code);
    repeat (4) @(posedge clk);
    #1;
    if (acMode) begin
      riseEvt = code[0]; fallEvt = code[1];
      aboveHi = 1'($urandom); belowLo = 1'($urandom);
    end else begin
      aboveHi = code[0]; belowLo = code[1];
      riseEvt = 1'($urandom); fallEvt = 1'($urandom);
    end
    if (code == 2'd1) begin mHyst = 1'b1; mEvt = 1'b1; end
    if (code == 2'd2) begin mHyst = 1'b0; mEvt = 1'b1; end
    @(posedge clk); #1;
    riseEvt = 0; fallEvt = 0; aboveHi = 0; belowLo = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic tckCycle(input logic [3:0] st, input logic [1:0] hiCode,
                          input logic [1:0] loCode, input string tag);
    @(posedge clk); #1;
    tck = 1'b1;
    tapState = st;
    if (lastFall == S_CAPDR && mEvt) mCapt = mHyst;
    phase(hiCode);
    @(posedge clk); #1;
    tck = 1'b0;
    lastFall = st;
    if ((acMode && st == S_EXIT1DR) || (!acMode && st == S_CAPDR)) mEvt = 1'b0;
    phase(loCode);
    #1;
    check({tag, " hyst"}, hystBit, mHyst);
    check({tag, " capt"}, captBit, mCapt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [3:0] st;
    void'($urandom(32'h5eed_0a17));
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset hyst", hystBit, 1'b0);
    check("R1 reset capt", captBit, 1'b0);

    // R3/R5/R7: level mode, high level inside capture window is loaded
    acMode = 1'b0;
    tckCycle(S_IDLE,    2'd0, 2'd0, "R3 idle");
    tckCycle(S_SELDR,   2'd0, 2'd0, "R3 seldr");
    tckCycle(S_CAPDR,   2'd0, 2'd1, "R3 level high");
    tckCycle(S_SHIFTDR, 2'd0, 2'd0, "R7 load high");
    // R5: low level before the clear point only; capture keeps 1
    tckCycle(S_EXIT1DR, 2'd0, 2'd0, "R5 exit1");
    tckCycle(S_UPDDR,   2'd2, 2'd0, "R3 level low");
    tckCycle(S_SELDR,   2'd0, 2'd0, "R5 seldr");
    tckCycle(S_CAPDR,   2'd0, 2'd0, "R5 cleared no event");
    tckCycle(S_SHIFTDR, 2'd0, 2'd0, "R7 hold no event");
    // R4: both levels inside window; hyst stays 0, capture keeps 1
    tckCycle(S_EXIT1DR, 2'd0, 2'd0, "R4 exit1");
    tckCycle(S_UPDDR,   2'd0, 2'd0, "R4 upd");
    tckCycle(S_SELDR,   2'd0, 2'd0, "R4 seldr");
    tckCycle(S_CAPDR,   2'd0, 2'd3, "R4 both levels");
    tckCycle(S_SHIFTDR, 2'd0, 2'd0, "R4 capture held");

    // R2/R6: edge mode, rising edge after Exit1DR clear is captured
    acMode = 1'b1;
    tckCycle(S_EXIT1DR, 2'd0, 2'd0, "R6 exit1");
    tckCycle(S_UPDDR,   2'd2, 2'd0, "R2 falling edge");
    tckCycle(S_IDLE,    2'd1, 2'd0, "R2 rising edge");
    tckCycle(S_SELDR,   2'd0, 2'd0, "R2 seldr");
    tckCycle(S_CAPDR,   2'd0, 2'd0, "R6 no clear in capdr");
    tckCycle(S_SHIFTDR, 2'd2, 2'd0, "R7 edge load");
    // R6: falling edge only before Exit1DR; capture keeps prior value
    tckCycle(S_EXIT1DR, 2'd0, 2'd0, "R6 clear");
    tckCycle(S_UPDDR,   2'd0, 2'd0, "R6 upd");
    tckCycle(S_SELDR,   2'd0, 2'd0, "R6 seldr");
    tckCycle(S_CAPDR,   2'd0, 2'd0, "R6 capdr");
    tckCycle(S_SHIFTDR, 2'd0, 2'd0, "R6 hold after clear");
    // R4 in edge mode
    tckCycle(S_EXIT1DR, 2'd0, 2'd3, "R4 both edges");
    tckCycle(S_UPDDR,   2'd3, 2'd0, "R4 both edges again");
    tckCycle(S_SELDR,   2'd0, 2'd0, "R4 seldr");
    tckCycle(S_CAPDR,   2'd0, 2'd0, "R4 capdr");
    tckCycle(S_SHIFTDR, 2'd0, 2'd0, "R4 edge capture held");

    // R7 random walk of the TAP graph with random events and modes
    st = S_SHIFTDR;
    for (int i = 0; i < 400; i++) begin
      st = nextTap(st, 1'($urandom));
      if (st == S_IDLE && ($urandom % 3 == 0)) acMode = ~acMode;
      tckCycle(st, 2'($urandom), ($urandom % 2 == 0) ? 2'd0 : 2'($urandom), "R7 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule